// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block produces a serial test bit stream for line or link testing, one bit for each cycle in which the bit-enable strobe is high. One set of configuration inputs serves two modes. In the repeating mode the low bits of a 32-bit pattern word are sent out cyclically. In the pseudo-random mode the same low bits are the seed of a linear feedback shift register whose length and feedback tap are both programmable.

Errors can be placed into the stream in two ways. A single-event input flips exactly one output bit per rising edge. A rate code flips one bit in every 10^n bits. A final invert control complements the whole stream. Each produced bit leaves a register together with a valid flag, one cycle after its enable strobe. The load strobe restarts the pattern from its first bit, or from the seed, and restarts the error-rate count.

Top module: `pattern_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, outValid and outBit are 0.
- R2: outValid is 1 exactly one cycle after a cycle in which bitEn is 1 and loadStb is 0, and 0 otherwise. outBit changes only in those cycles.
- R3: The active length X equals cfgLen, and a cfgLen of 0 is treated as 1. Only bits [X:0] of cfgWord are used.
- R4: When cfgMode is 0 (repeating), the bits sent after a load are cfgWord[0], cfgWord[1], and so on up to cfgWord[X], and then the sequence starts again from bit 0.
- R5: When cfgMode is 1 (pseudo-random), a load sets the state to cfgWord[X:0]. Each produced bit is state[X]. The state then shifts one place toward the MSB, and its new bit 0 is state[X] XOR state[T], where T is cfgTap. A tap of X or more is treated as 0.
- R6: When cfgMode is 1, an all-zero seed in bits [X:0] is replaced by all ones in bits [X:0].
- R7: When cfgInvert is 1, every produced bit is complemented.
- R8: Each rising edge of errEvent flips exactly one produced bit: the bit of that same cycle if bitEn is 1 and loadStb is 0, otherwise the next produced bit. Holding errEvent high flips no further bits.
- R9: With cfgRate = n in the range 1 to 7, counting from the last load, the 10^n-th produced bit and every 10^n-th bit after it are flipped. A cfgRate of 0 flips no bits.
- R10: In a cycle with both loadStb and bitEn at 1, the load takes effect and no bit is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 1 | 0 repeating word, 1 pseudo-random |
| cfgLen | input | 5 | Active length X (bits [X:0]) |
| cfgWord | input | 32 | Pattern word or seed |
| cfgTap | input | 5 | Feedback tap position |
| cfgInvert | input | 1 | Complement output stream |
| cfgRate | input | 3 | Continuous error rate code |
| loadStb | input | 1 | Reload seed, pointer and rate counter |
| bitEn | input | 1 | Produce one bit this cycle |
| errEvent | input | 1 | Single error request (edge detected) |
| outBit | output | 1 | Output bit |
| outValid | output | 1 | outBit is new this cycle |

## Verification
The repeating mode is driven with an odd short word, with the length-zero corner and with a full 32-bit word. These show whether the pointer wraps at the right bit and whether the bit order is correct. The pseudo-random mode is run with a short register at a mid tap, with a full-width register and with an out-of-range tap. The bench model predicts each bit, so an error in the feedback, the shift direction or the masking breaks the match. An all-zero seed, a held-high event request, rate codes 0, 1 and 2 over an all-zero word, inversion, and a load that collides with an enable each isolate one control path.

// File: rtl/pg_pkg.sv
package pg_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // reload seed / pointer
    logic advance;  // produce one bit this cycle
    logic flip;     // invert the bit being produced
  } pgStrobe_t;
endpackage

// File: rtl/pg_control.sv
module pg_control #(
  parameter int RATE_W = 3,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic              bitEn,
  input  logic              errEvent,
  input  logic [RATE_W-1:0] cfgRate,
  output pg_pkg::pgStrobe_t stb
);
  localparam int CODES = 1 << RATE_W;

  // 10^code - 1, computed
  function automatic logic [CNT_W-1:0] rateReload(input logic [RATE_W-1:0] code);
    logic [CNT_W-1:0] v;
    v = CNT_W'(1);
    for (int i = 1; i < CODES; i++)
      if (i <= int'(code)) v = v * CNT_W'(10);
    return v - CNT_W'(1);
  endfunction

  logic             evtPrev;
  logic             evtPending;
  logic             evtNow;
  logic [CNT_W-1:0] rateCnt;
  logic             rateHit;
  logic             adv;

  assign adv     = bitEn & ~loadStb;
  assign evtNow  = evtPending | (errEvent & ~evtPrev);
  assign rateHit = (cfgRate != '0) && (rateCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPrev    <= 1'b0;
      evtPending <= 1'b0;
    end else begin
      evtPrev    <= errEvent;
      evtPending <= evtNow & ~adv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateCnt <= '1;
    end else if (loadStb) begin
      rateCnt <= rateReload(cfgRate);
    end else if (adv) begin
      if (rateCnt == '0) rateCnt <= rateReload(cfgRate);
      else               rateCnt <= rateCnt - CNT_W'(1);
    end
  end

  always_comb begin
    stb.load    = loadStb;
    stb.advance = adv;
    stb.flip    = adv & (evtNow | rateHit);
  end
endmodule

// File: rtl/pg_datapath.sv
module pg_datapath #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  pg_pkg::pgStrobe_t stb,
  input  logic              cfgMode,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic [LEN_W-1:0]  cfgTap,
  input  logic              cfgInvert,
  output logic              outBit,
  output logic              outValid,
  output logic [WORD_W-1:0] stateOut
);
  logic [LEN_W-1:0]  effLen;
  logic [LEN_W-1:0]  effTap;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] seedRaw;
  logic [WORD_W-1:0] seed;
  logic [WORD_W-1:0] lfsr;
  logic [LEN_W-1:0]  ptr;
  logic              fb;
  logic              genBit;

  assign effLen = (cfgLen == '0) ? LEN_W'(1) : cfgLen;
  assign effTap = (cfgTap < effLen) ? cfgTap : '0;

  for (genvar g = 0; g < WORD_W; g++) begin : g_mask
    assign mask[g] = (effLen >= LEN_W'(g));
  end

  assign seedRaw = cfgWord & mask;
  assign seed    = (cfgMode && seedRaw == '0) ? mask : seedRaw;
  assign fb      = lfsr[effLen] ^ lfsr[effTap];
  assign genBit  = cfgMode ? lfsr[effLen] : cfgWord[ptr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr <= '1;
      ptr  <= '0;
    end else if (stb.load) begin
      lfsr <= seed;
      ptr  <= '0;
    end else if (stb.advance) begin
      if (cfgMode) lfsr <= {lfsr[WORD_W-2:0], fb} & mask;
      else         ptr  <= (ptr >= effLen) ? '0 : ptr + LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBit   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= stb.advance;
      if (stb.advance) outBit <= genBit ^ cfgInvert ^ stb.flip;
    end
  end

  assign stateOut = lfsr;
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen #(
  parameter int WORD_W = 32,
  parameter int RATE_W = 3,
  parameter int CNT_W  = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgMode,
  input  logic [$clog2(WORD_W)-1:0]  cfgLen,
  input  logic [WORD_W-1:0]          cfgWord,
  input  logic [$clog2(WORD_W)-1:0]  cfgTap,
  input  logic                       cfgInvert,
  input  logic [RATE_W-1:0]          cfgRate,
  input  logic                       loadStb,
  input  logic                       bitEn,
  input  logic                       errEvent,
  output logic                       outBit,
  output logic                       outValid
);
  localparam int LEN_W = $clog2(WORD_W);

  pg_pkg::pgStrobe_t stb;
  logic [WORD_W-1:0] stateW;

  pg_control #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .bitEn(bitEn),
    .errEvent(errEvent), .cfgRate(cfgRate), .stb(stb)
  );

  pg_datapath #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgMode(cfgMode), .cfgLen(cfgLen),
    .cfgWord(cfgWord), .cfgTap(cfgTap), .cfgInvert(cfgInvert),
    .outBit(outBit), .outValid(outValid), .stateOut(stateW)
  );
endmodule

// File: rtl/pg_checker.sv
module pg_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitEn,
  input logic              loadStb,
  input logic              cfgMode,
  input logic              outBit,
  input logic              outValid,
  input pg_pkg::pgStrobe_t stb,
  input logic [WORD_W-1:0] stateW
);
  // R2: valid follows an un-collided enable by one cycle
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(bitEn && !loadStb));

  // R2: the output bit holds when no bit is produced
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!(bitEn && !loadStb)) |-> $stable(outBit));

  // R8/R9: a flip only ever lands on a produced bit
  p_flip_on_bit_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.flip |-> stb.advance);

  // R6: after a pseudo-random load the register is never all zero
  p_seed_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadStb && cfgMode) |-> stateW != '0);

  // R10: a load colliding with an enable produces no bit
  p_collide_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && bitEn) |=> !outValid);
endmodule

bind pattern_gen pg_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .loadStb(loadStb),
  .cfgMode(cfgMode), .outBit(outBit), .outValid(outValid),
  .stb(stb), .stateW(stateW)
);

// File: tb/tb_pattern_gen.sv
`timescale 1ns/1ps
module tb_pattern_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMode = 1'b0;
  logic [4:0]  cfgLen = '0;
  logic [31:0] cfgWord = '0;
  logic [4:0]  cfgTap = '0;
  logic        cfgInvert = 1'b0;
  logic [2:0]  cfgRate = '0;
  logic        loadStb = 1'b0;
  logic        bitEn = 1'b0;
  logic        errEvent = 1'b0;
  logic        outBit;
  logic        outValid;

  int errors = 0;
  int checks = 0;
  logic [31:0] mState;
  int          mPtr;

  always #2 clk = ~clk;

  pattern_gen dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgLen(cfgLen),
    .cfgWord(cfgWord), .cfgTap(cfgTap), .cfgInvert(cfgInvert),
    .cfgRate(cfgRate), .loadStb(loadStb), .bitEn(bitEn),
    .errEvent(errEvent), .outBit(outBit), .outValid(outValid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int xLen();
    return (cfgLen == 0) ? 1 : int'(cfgLen);
  endfunction

  function automatic logic [31:0] xMask();
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = (i <= xLen());
    return m;
  endfunction

  // reference model load (R3, R4, R5, R6)
  task automatic mLoad();
    mState = cfgWord & xMask();
    if (cfgMode && mState == 0) mState = xMask();
    mPtr = 0;
  endtask

  task automatic mStep(output logic b);
    int x, t;
    x = xLen();
    t = (int'(cfgTap) < x) ? int'(cfgTap) : 0;
    if (cfgMode) begin
      b = mState[x];
      mState = ({mState[30:0], mState[x] ^ mState[t]}) & xMask();
    end else begin
      b = cfgWord[mPtr];
      mPtr = (mPtr >= x) ? 0 : mPtr + 1;
    end
  endtask

  task automatic doLoad();
    @(negedge clk); loadStb = 1'b1;
    @(negedge clk); loadStb = 1'b0;
    mLoad();
  endtask

  // n consecutive bits; flips every period bits (0 = none) and at evtIdx
  task automatic runSeq(input string req, input int n, input int period, input int evtIdx);
    logic b;
    for (int i = 0; i < n; i++) begin
      bitEn = 1'b1;
      @(negedge clk);
      mStep(b);
      if (cfgInvert) b = ~b;
      if (period > 0 && ((i + 1) % period) == 0) b = ~b;
      if (i == evtIdx) b = ~b;
      chk({req, " valid"}, outValid, 1);
      chk({req, " bit"}, outBit, b);
    end
    bitEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 valid in reset", outValid, 0);
    chk("R1 bit in reset", outBit, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", outValid, 0);
    chk("R1 bit after reset", outBit, 0);
  endtask

  task automatic tRepeat();
    cfgMode = 0; cfgRate = 0; cfgInvert = 0;
    cfgLen = 7; cfgWord = 32'h0000_00A5; doLoad(); runSeq("R4 len7", 20, 0, -1);
    cfgLen = 0; cfgWord = 32'h0000_0002; doLoad(); runSeq("R3 len0", 6, 0, -1);
    cfgLen = 31; cfgWord = 32'hDEAD_BEEF; doLoad(); runSeq("R4 len31", 40, 0, -1);
  endtask

  task automatic tPrbs();
    cfgMode = 1; cfgRate = 0; cfgInvert = 0;
    cfgLen = 6; cfgTap = 4; cfgWord = 32'hFFFF_FF2D; doLoad(); runSeq("R5 len6", 40, 0, -1);
    cfgLen = 31; cfgTap = 27; cfgWord = 32'h0000_0001; doLoad(); runSeq("R5 len31", 64, 0, -1);
    cfgLen = 4; cfgTap = 9; cfgWord = 32'h0000_0013; doLoad(); runSeq("R5 tap>=X", 20, 0, -1);
  endtask

  task automatic tZeroSeed();
    cfgMode = 1; cfgLen = 5; cfgTap = 2; cfgWord = 32'hFFFF_FFC0; doLoad();
    runSeq("R6 zero seed", 30, 0, -1);
  endtask

  task automatic tInvert();
    cfgMode = 0; cfgLen = 7; cfgWord = 32'h0000_00C3; cfgInvert = 1; doLoad();
    runSeq("R7 invert", 16, 0, -1);
    cfgInvert = 0;
  endtask

  task automatic tEvent();
    cfgMode = 0; cfgLen = 31; cfgWord = 0; cfgRate = 0; doLoad();
    @(negedge clk); errEvent = 1'b1;   // rise together with bitEn
    runSeq("R8 event same cycle held", 10, 0, 0);
    errEvent = 1'b0; @(negedge clk);
    errEvent = 1'b1; @(negedge clk); @(negedge clk);  // rise while idle
    chk("R8 idle no bit", outValid, 0);
    runSeq("R8 event pending", 8, 0, 0);
    errEvent = 1'b0;
  endtask

  task automatic tRate();
    cfgMode = 0; cfgLen = 31; cfgWord = 0;
    cfgRate = 0; doLoad(); runSeq("R9 rate0", 50, 0, -1);
    cfgRate = 1; doLoad(); runSeq("R9 rate1", 30, 10, -1);
    cfgRate = 2; doLoad(); runSeq("R9 rate2", 200, 100, -1);
    cfgRate = 0;
  endtask

  task automatic tCollide();
    cfgMode = 0; cfgLen = 3; cfgWord = 32'h0000_0006; doLoad();
    runSeq("R10 before", 2, 0, -1);
    @(negedge clk); loadStb = 1'b1; bitEn = 1'b1;
    @(negedge clk); loadStb = 1'b0; bitEn = 1'b0;
    mLoad();
    chk("R10 no bit on collision", outValid, 0);
    runSeq("R10 after", 4, 0, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tRepeat();
    tPrbs();
    tZeroSeed();
    tInvert();
    tEvent();
    tRate();
    tCollide();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule